// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Manager

This block moves an EDO DRAM into and out of its low-power self-refresh state. When the system asks to sleep, the manager takes the RAS, CAS and WE strobes from the host path. It runs a complete burst of CAS-before-RAS refresh cycles over every row. It then lowers CAS and RAS once more and holds both low, which places the device in self refresh. A wake request ends the hold, but only after RAS has stayed low past the minimum self-refresh time. The manager then applies the extended precharge that self refresh requires, runs a second full refresh burst, and hands the strobes back to the host.

The manager does not begin an episode unless the whole array is known to be fresh. After reset that knowledge comes from the refresh scheduler: each distributed row refresh it completes raises a one-cycle pulse. The manager counts these pulses. The closing burst of each episode sets the same knowledge directly. A sleep request that arrives while the host access sequencer is busy is held until the sequencer reports idle. All timing values are given in clock cycles. The default values assume a 200 MHz clock and a 4096-row device.

Top module: `srm_selfref_mgr`

## Requirements
- R1: After reset, and whenever `mgr_owns` is low, `ras_n`, `cas_n` and `we_n` are all high (released), and `mgr_owns` and `asleep` are low.
- R2: Every falling edge of `ras_n` driven by the manager finds `cas_n` already low in the cycle before. `we_n` stays high for as long as the manager owns the strobes.
- R3: Between the rise of `mgr_owns` and the rise of `asleep`, exactly ROWS CAS-before-RAS cycles are issued.
- R4: While `asleep` is high and `ras_n` is low, `cas_n` is low. The self-refresh RAS-low period lasts longer than SR_MIN_CYC cycles. A wake request that arrives early releases RAS after exactly SR_MIN_CYC+1 low cycles.
- R5: In refresh bursts, each RAS-low pulse lasts T_RAS cycles. This stays below FORBID_LO_CYC, where the forbidden transition window begins.
- R6: After the self-refresh RAS-low period ends, `ras_n` stays high for at least T_RPS cycles before it falls again.
- R7: After self-refresh exit, exactly ROWS CAS-before-RAS cycles are issued before `mgr_owns` falls. `asleep` is low during these cycles.
- R8: After reset, sleep requests are discarded, not remembered, until ROWS `sched_row_done` pulses have been counted. Once the count is complete, or once an episode's closing burst has finished, a sleep request with `seq_idle` high makes `mgr_owns` go high on the next cycle.
- R9: A sleep request made while `seq_idle` is low is held. `mgr_owns` goes high on the cycle after `seq_idle` rises.
- R10: A wake request is ignored while the host owns the strobes. A sleep request is ignored while the manager owns them. A wake request made after the minimum hold has passed releases RAS two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle request to enter self refresh |
| wake_req | input | 1 | One-cycle request to leave self refresh |
| seq_idle | input | 1 | High when the host access sequencer has no access in flight |
| sched_row_done | input | 1 | One-cycle pulse from the refresh scheduler for each distributed row refresh |
| ras_n | output | 1 | Row strobe level, active low |
| cas_n | output | 1 | Column strobe level, active low |
| we_n | output | 1 | Write-enable level, active low (held high) |
| mgr_owns | output | 1 | High while the manager, not the host, drives the strobes |
| asleep | output | 1 | High from the end of the entry burst until the self-refresh precharge completes |

## Verification
The hardest case to reach is the exact release point of an early wake. RAS must rise on the first cycle after the low period exceeds the minimum, neither sooner nor later. The bench reaches it by pulsing wake a few cycles into the hold and measuring the whole low run at the pins. A second case is the precharge gap that follows the long low period. The bench captures the high run before the first fall of the closing burst and checks it against T_RPS. A third case is the refresh-credit gate after reset. The bench brings it out by supplying one scheduler pulse too few, showing that sleep is refused, and then supplying the last pulse.

// File: rtl/srm_pkg.sv
package srm_pkg;

    typedef enum logic [1:0] {
        MS_RUN,
        MS_PRE_BURST,
        MS_SELF,
        MS_POST_BURST
    } mgr_state_e;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_SETUP,
        GS_LOW,
        GS_PRE
    } gen_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // width able to hold the values 0 .. n-1
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_of2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srm_strobe_gen.sv
module srm_strobe_gen
    import srm_pkg::*;
#(
    parameter int unsigned T_CSR = 1,
    parameter int unsigned T_RAS = 12,
    parameter int unsigned T_RP  = 8,
    parameter int unsigned T_RPS = 22
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    hold_mode,
    input  logic    rel_req,
    output strobe_t strobe,
    output logic    idle,
    output logic    done,
    output logic    in_hold_low
);
    localparam int unsigned MAXT = max_of2(max_of2(T_CSR, T_RAS), max_of2(T_RP, T_RPS));
    localparam int unsigned CW   = cnt_w(MAXT);

    gen_state_e     st;
    logic [CW-1:0]  cnt;
    logic           hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= GS_IDLE;
            cnt    <= '0;
            hold_q <= 1'b0;
        end else begin
            case (st)
                GS_IDLE: begin
                    if (start) begin
                        st     <= GS_SETUP;
                        cnt    <= CW'(T_CSR - 1);
                        hold_q <= hold_mode;
                    end
                end
                GS_SETUP: begin
                    if (cnt == '0) begin
                        st  <= GS_LOW;
                        cnt <= CW'(T_RAS - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                GS_LOW: begin
                    if (hold_q) begin
                        if (rel_req) begin
                            st  <= GS_PRE;
                            cnt <= CW'(T_RPS - 1);
                        end
                    end else if (cnt == '0) begin
                        st  <= GS_PRE;
                        cnt <= CW'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                GS_PRE: begin
                    if (cnt == '0) begin
                        st     <= GS_IDLE;
                        hold_q <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= GS_IDLE;
            endcase
        end
    end

    always_comb begin
        strobe = STROBE_REST;
        case (st)
            GS_SETUP: strobe.cas_n = 1'b0;
            GS_LOW: begin
                strobe.cas_n = 1'b0;
                strobe.ras_n = 1'b0;
            end
            default: strobe = STROBE_REST;
        endcase
    end

    assign idle        = (st == GS_IDLE);
    assign done        = (st == GS_PRE) && (cnt == '0);
    assign in_hold_low = (st == GS_LOW) && hold_q;

endmodule

// File: rtl/srm_lowtime_timer.sv
module srm_lowtime_timer
    import srm_pkg::*;
#(
    parameter int unsigned SR_MIN_CYC = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic min_met
);
    localparam int unsigned TW = cnt_w(SR_MIN_CYC + 1);

    logic [TW-1:0] cnt;

    // saturates at the limit, so reaching the limit equals passing it
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != TW'(SR_MIN_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign min_met = run && (cnt == TW'(SR_MIN_CYC));

endmodule

// File: rtl/srm_row_tally.sv
module srm_row_tally
    import srm_pkg::*;
#(
    parameter int unsigned ROWS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last_hit
);
    localparam int unsigned RW = cnt_w(ROWS);

    logic [RW-1:0] cnt;
    logic          at_last;

    assign at_last  = (cnt == RW'(ROWS - 1));
    assign last_hit = inc && at_last;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/srm_selfref_mgr.sv
module srm_selfref_mgr
    import srm_pkg::*;
#(
    parameter int unsigned ROWS          = 4096,
    parameter int unsigned T_CSR         = 1,
    parameter int unsigned T_RAS         = 12,
    parameter int unsigned T_RP          = 8,
    parameter int unsigned T_RPS         = 22,
    parameter int unsigned SR_MIN_CYC    = 20000,
    parameter int unsigned FORBID_LO_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic seq_idle,
    input  logic sched_row_done,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic mgr_owns,
    output logic asleep
);
    // burst pulses are clipped below the start of the forbidden window
    localparam int unsigned T_RAS_EFF = (T_RAS < FORBID_LO_CYC) ? T_RAS : FORBID_LO_CYC - 1;

    mgr_state_e st;
    logic       all_ref;
    logic       sleep_pend;
    logic       wake_pend;
    logic       sr_launched;

    logic       go;
    logic       in_burst;
    logic       gen_start;
    logic       gen_idle;
    logic       gen_done;
    logic       hold_low;
    logic       min_met;
    logic       burst_clr;
    logic       burst_hit;
    logic       credit_inc;
    logic       credit_hit;
    strobe_t    gen_strobe;
    strobe_t    pin_strobe;

    assign in_burst  = (st == MS_PRE_BURST) || (st == MS_POST_BURST);
    assign go        = (st == MS_RUN) && seq_idle && all_ref && (sleep_pend || sleep_req);
    assign gen_start = gen_idle && (in_burst || ((st == MS_SELF) && !sr_launched));
    assign burst_clr = go || ((st == MS_SELF) && gen_done);
    assign credit_inc = sched_row_done && (st == MS_RUN) && !all_ref;

    srm_strobe_gen #(
        .T_CSR (T_CSR),
        .T_RAS (T_RAS_EFF),
        .T_RP  (T_RP),
        .T_RPS (T_RPS)
    ) u_gen (
        .clk         (clk),
        .rst         (rst),
        .start       (gen_start),
        .hold_mode   (st == MS_SELF),
        .rel_req     (wake_pend && min_met),
        .strobe      (gen_strobe),
        .idle        (gen_idle),
        .done        (gen_done),
        .in_hold_low (hold_low)
    );

    srm_lowtime_timer #(
        .SR_MIN_CYC (SR_MIN_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (hold_low),
        .min_met (min_met)
    );

    srm_row_tally #(
        .ROWS (ROWS)
    ) u_burst_tally (
        .clk      (clk),
        .rst      (rst),
        .clr      (burst_clr),
        .inc      (gen_done && in_burst),
        .last_hit (burst_hit)
    );

    srm_row_tally #(
        .ROWS (ROWS)
    ) u_credit_tally (
        .clk      (clk),
        .rst      (rst),
        .clr      (1'b0),
        .inc      (credit_inc),
        .last_hit (credit_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= MS_RUN;
            all_ref     <= 1'b0;
            sleep_pend  <= 1'b0;
            wake_pend   <= 1'b0;
            sr_launched <= 1'b0;
        end else begin
            if (credit_hit) begin
                all_ref <= 1'b1;
            end
            case (st)
                MS_RUN: begin
                    if (go) begin
                        st         <= MS_PRE_BURST;
                        sleep_pend <= 1'b0;
                        wake_pend  <= 1'b0;
                        all_ref    <= 1'b0;
                    end else if (sleep_req && all_ref) begin
                        sleep_pend <= 1'b1;
                    end
                end
                MS_PRE_BURST: begin
                    if (wake_req) begin
                        wake_pend <= 1'b1;
                    end
                    if (burst_hit) begin
                        st <= MS_SELF;
                    end
                end
                MS_SELF: begin
                    if (gen_start) begin
                        sr_launched <= 1'b1;
                    end
                    if (gen_done) begin
                        st          <= MS_POST_BURST;
                        sr_launched <= 1'b0;
                        wake_pend   <= 1'b0;
                    end else if (wake_req) begin
                        wake_pend <= 1'b1;
                    end
                end
                MS_POST_BURST: begin
                    if (burst_hit) begin
                        st      <= MS_RUN;
                        all_ref <= 1'b1;
                    end
                end
                default: st <= MS_RUN;
            endcase
        end
    end

    assign pin_strobe = (st == MS_RUN) ? STROBE_REST : gen_strobe;
    assign ras_n      = pin_strobe.ras_n;
    assign cas_n      = pin_strobe.cas_n;
    assign we_n       = pin_strobe.we_n;
    assign mgr_owns   = (st != MS_RUN);
    assign asleep     = (st == MS_SELF);

endmodule

// File: rtl/srm_selfref_chk.sv
module srm_selfref_chk #(
    parameter int unsigned T_RAS         = 12,
    parameter int unsigned T_RPS         = 22,
    parameter int unsigned SR_MIN_CYC    = 20000,
    parameter int unsigned FORBID_LO_CYC = 2000
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic mgr_owns,
    input logic asleep
);
    int unsigned low_run;
    int unsigned hi_run;
    logic        prev_ras;
    logic        prev_asleep;
    logic        after_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run     <= 0;
            hi_run      <= 0;
            prev_ras    <= 1'b1;
            prev_asleep <= 1'b0;
            after_sr    <= 1'b0;
        end else begin
            low_run     <= ras_n ? 0 : low_run + 1;
            hi_run      <= ras_n ? hi_run + 1 : 0;
            prev_ras    <= ras_n;
            prev_asleep <= asleep;
            if (ras_n && !prev_ras && prev_asleep) begin
                after_sr <= 1'b1;
            end else if (!ras_n && prev_ras) begin
                after_sr <= 1'b0;
            end
        end
    end

    AST_REST_WHEN_HOST: assert property (@(posedge clk) disable iff (rst)
        !mgr_owns |-> (ras_n && cas_n && we_n && !asleep)); // R1

    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
        (mgr_owns && $fell(ras_n)) |-> $past(!cas_n)); // R2

    AST_WE_HELD: assert property (@(posedge clk) disable iff (rst)
        mgr_owns |-> we_n); // R2

    AST_SR_CAS_LOW: assert property (@(posedge clk) disable iff (rst)
        (asleep && !ras_n) |-> !cas_n); // R4

    AST_SR_LONG: assert property (@(posedge clk) disable iff (rst)
        ($rose(ras_n) && $past(asleep)) |-> (low_run > SR_MIN_CYC)); // R4

    AST_BURST_SHORT: assert property (@(posedge clk) disable iff (rst)
        ($rose(ras_n) && !$past(asleep)) |-> (low_run == T_RAS && low_run < FORBID_LO_CYC)); // R5

    AST_RPS_GAP: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && after_sr) |-> (hi_run >= T_RPS)); // R6

endmodule

bind srm_selfref_mgr srm_selfref_chk #(
    .T_RAS         (T_RAS_EFF),
    .T_RPS         (T_RPS),
    .SR_MIN_CYC    (SR_MIN_CYC),
    .FORBID_LO_CYC (FORBID_LO_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .mgr_owns (mgr_owns),
    .asleep   (asleep)
);

// File: tb/srm_selfref_mgr_test.sv
`timescale 1ns/100ps
module srm_selfref_mgr_test;
    localparam int ROWS   = 8;
    localparam int T_CSR  = 1;
    localparam int T_RAS  = 3;
    localparam int T_RP   = 2;
    localparam int T_RPS  = 5;
    localparam int SR_MIN = 40;
    localparam int FORBID = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0;
    logic wake_req = 1'b0;
    logic seq_idle = 1'b1;
    logic sched_row_done = 1'b0;
    logic ras_n, cas_n, we_n, mgr_owns, asleep;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // pin monitor state
    int   falls = 0, bad_order = 0, short_max = 0, sr_low = 0, post_hi = 0;
    int   low_len = 0, hi_len = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, after_long = 1'b0;

    always #2.5 clk = ~clk;

    srm_selfref_mgr #(
        .ROWS (ROWS), .T_CSR (T_CSR), .T_RAS (T_RAS), .T_RP (T_RP),
        .T_RPS (T_RPS), .SR_MIN_CYC (SR_MIN), .FORBID_LO_CYC (FORBID)
    ) uut (
        .clk (clk), .rst (rst), .sleep_req (sleep_req), .wake_req (wake_req),
        .seq_idle (seq_idle), .sched_row_done (sched_row_done),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .mgr_owns (mgr_owns), .asleep (asleep)
    );

    always @(negedge clk) begin
        if (rst) begin
            prev_ras = 1'b1; prev_cas = 1'b1; low_len = 0; hi_len = 0; after_long = 1'b0;
        end else begin
            if (!ras_n) begin
                if (prev_ras) begin
                    falls++;
                    if (prev_cas) bad_order++;
                    if (after_long) begin post_hi = hi_len; after_long = 1'b0; end
                    low_len = 1;
                end else low_len++;
            end else begin
                if (!prev_ras) begin
                    if (low_len > FORBID) begin sr_low = low_len; after_long = 1'b1; end
                    else if (low_len > short_max) short_max = low_len;
                    hi_len = 1;
                end else hi_len++;
            end
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        checks++;
        if (act < lim) begin
            fails++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    task automatic clr_mon();
        falls = 0; bad_order = 0; short_max = 0; sr_low = 0; post_hi = 0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1; step(); wake_req = 1'b0;
    endtask

    task automatic credit(input int n);
        for (int i = 0; i < n; i++) begin
            sched_row_done = 1'b1; step(); sched_row_done = 1'b0; step();
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 strobes at reset", {ras_n, cas_n, we_n}, 3'b111);
        chk("R1 owns/asleep at reset", {mgr_owns, asleep}, 2'b00);
    endtask

    // remainder of an episode once mgr_owns has risen
    task automatic episode(input bit late, input string tag);
        for (int i = 0; i < 2000 && !asleep; i++) step();
        chk({"R3 entry burst count ", tag}, falls, ROWS);
        chk({"R5 burst low width ", tag}, short_max, T_RAS);
        if (late) begin
            pulse_sleep();
            repeat (SR_MIN + 15) step();
            chk("R4 held low with CAS low", {ras_n, cas_n, we_n, asleep}, 4'b0011);
            pulse_wake();
            chk("R10 RAS low one cycle after wake", ras_n, 0);
            step();
            chk("R10 RAS high two cycles after wake", ras_n, 1);
        end else begin
            repeat (3) step();
            pulse_wake();
        end
        for (int i = 0; i < 2000 && asleep; i++) step();
        if (late) chk_ge("R4 long low width", sr_low, SR_MIN + 1);
        else chk({"R4 early wake low width ", tag}, sr_low, SR_MIN + 1);
        falls = 0;
        for (int i = 0; i < 2000 && mgr_owns; i++) step();
        chk({"R7 exit burst count ", tag}, falls, ROWS);
        chk_ge({"R6 precharge after self refresh ", tag}, post_hi, T_RPS);
        chk({"R2 CAS before RAS ", tag}, bad_order, 0);
        chk({"R1 strobes released ", tag}, {ras_n, cas_n, we_n, asleep}, 4'b1110);
    endtask

    task automatic t_credit_gate();
        pulse_sleep();
        repeat (4) step();
        chk("R8 sleep without credit ignored", mgr_owns, 0);
        credit(ROWS - 1);
        pulse_sleep();
        repeat (4) step();
        chk("R8 sleep one credit short ignored", mgr_owns, 0);
        credit(1);
        repeat (4) step();
        chk("R8 earlier request not remembered", mgr_owns, 0);
        clr_mon();
        pulse_sleep();
        chk("R8 sleep accepted after full credit", mgr_owns, 1);
        episode(1'b0, "first");
    endtask

    task automatic t_reentry();
        clr_mon();
        pulse_sleep();
        chk("R8 direct re-entry after closing burst", mgr_owns, 1);
        episode(1'b1, "late wake");
        repeat (5) step();
        chk("R10 sleep during episode ignored", mgr_owns, 0);
    endtask

    task automatic t_defer();
        seq_idle = 1'b0;
        clr_mon();
        pulse_sleep();
        repeat (5) step();
        chk("R9 sleep held while busy", mgr_owns, 0);
        seq_idle = 1'b1;
        step();
        chk("R9 owns cycle after idle", mgr_owns, 1);
        episode(1'b0, "deferred");
    endtask

    task automatic t_wake_ignored();
        pulse_wake();
        repeat (5) step();
        chk("R10 wake in run ignored", {mgr_owns, ras_n, cas_n, we_n}, 4'b0111);
        clr_mon();
        pulse_sleep();
        chk("R10 sleep after stray wake", mgr_owns, 1);
        episode(1'b0, "after stray wake");
    endtask

    initial begin
        t_reset();
        t_credit_gate();
        t_reentry();
        t_defer();
        t_wake_ignored();
        summary();
        $finish;
    end

endmodule